// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block holds the hazard and bypass control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access and write-back. Registers are read only in decode and written only in write-back. As a result, only read-after-write conflicts can arise. The block compares the source register numbers of the instructions in decode and execute against the destination numbers held further down the pipe. From that comparison it produces three kinds of output: mux selects for the execute operands, a stall that freezes the PC and the fetch/decode register and empties the decode/execute register, and the next-PC choice for branches.

Branches are resolved in decode. They test one register for zero or non-zero, so the block also picks the bypass source for that register and performs the test itself. It receives the register-file value, the ALU result held after execute, and the write-back value. A branch has one delay slot. The instruction already fetched behind it always proceeds, and only the PC is steered to the target.

The block is purely combinational. The datapath applies its outputs at the next clock edge.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute operand select is 1 (take the result after execute) when the memory-stage instruction writes that operand's register and the register is not 0.
- R2: When R1 does not apply and the write-back instruction writes the operand's register (not 0), the select is 2. In every other case it is 0 (register-file value).
- R3: When both the memory-stage and write-back-stage destinations match a source, the memory-stage result wins and the select is 1.
- R4: A destination or source of register 0 never produces a nonzero select, and never produces a stall.
- R5: A load in execute whose destination equals a source that the decode instruction uses raises the stall. When the stall is raised, pc_hold, ifid_hold and idex_bubble are all 1 in the same cycle.
- R6: A non-load instruction in execute that writes a register used by a non-branch decode instruction causes no stall, because bypassing covers it.
- R7: A branch in decode whose tested register is written by any instruction in execute stalls.
- R8: A branch in decode whose tested register is being loaded by the memory-stage instruction also stalls. A load placed directly before a dependent branch therefore costs two stall cycles, while a dependent ALU instruction costs one.
- R9: The branch operand select uses the code of R1/R2. It selects 1 only when the memory-stage writer is not a load. The tested value is the selected one of the register-file, memory-stage and write-back values.
- R10: take_target is 1 only when a branch in decode is not stalled and its condition holds. br_zero=1 means taken when the value equals zero; br_zero=0 means taken when it is nonzero. A taken branch never holds fetch/decode, so the delay-slot instruction proceeds.
- R11: A source whose use flag is 0 never causes a load-use stall.

Top module ports below use REG_AW=5 and XLEN=32 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source of the decode instruction (also the branch-tested register) |
| id_rs2 | input | REG_AW | Second source of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads id_rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads id_rs2 |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_zero | input | 1 | 1: branch if zero, 0: branch if nonzero |
| ex_rs1 | input | REG_AW | First source of the execute instruction |
| ex_rs2 | input | REG_AW | Second source of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| rf_rs1_val | input | XLEN | Register-file read of id_rs1 |
| mem_alu_val | input | XLEN | ALU result held after execute |
| wb_val | input | XLEN | Value being written back |
| fwd_a | output | 2 | Execute operand A select (0 reg, 1 memory stage, 2 write-back) |
| fwd_b | output | 2 | Execute operand B select |
| fwd_br | output | 2 | Branch operand select |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op (write enable cleared) into decode/execute |
| take_target | output | 1 | Load the PC with the branch target |

## Verification
Single-cycle input patterns cover several cases for the execute selects: a match in the memory stage alone, a match in write-back alone, a double match, and a match gated by a cleared write enable. These cases separate the priority rule from plain matching. Load-use patterns are run with the use flag set and clear, and with a non-load writer, to separate a real hazard from a false one. Branch patterns cover each bypass source against zero and nonzero values for both test senses, which shows that the tested value really comes from the chosen source. Short programs run through a behavioural pipeline model then count stall cycles: two for load-then-branch, one for load-then-use and for ALU-then-branch, and none with a spacer instruction.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      FS_REG = 2'd0,
      FS_MEM = 2'd1,
      FS_WB  = 2'd2
   } fwd_src_e;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_ok,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_ok,
   output fwd_src_e      sel
);
   logic src_live;
   logic mem_hit;
   logic wb_hit;

   assign src_live = |src;
   assign mem_hit  = src_live && mem_ok && (mem_rd == src);
   assign wb_hit   = src_live && wb_ok && (wb_rd == src);

   always_comb begin
      if (mem_hit)     sel = FS_MEM;
      else if (wb_hit) sel = FS_WB;
      else             sel = FS_REG;
   end

   always_comb begin
      if (!src_live)
         assert_zero_src_R4: assert (sel == FS_REG);
      if (sel == FS_WB)
         assert_young_first_R3: assert (!(mem_ok && (mem_rd == src)));
   end
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect #(
   parameter int AW   = 5,
   parameter int NSRC = 2
) (
   input  logic [NSRC-1:0][AW-1:0] srcs,
   input  logic [NSRC-1:0]         uses,
   input  logic                    id_branch,
   input  logic [AW-1:0]           ex_rd,
   input  logic                    ex_wen,
   input  logic                    ex_load,
   input  logic [AW-1:0]           mem_rd,
   input  logic                    mem_wen,
   input  logic                    mem_load,
   output logic                    stall
);
   logic [NSRC-1:0] ex_hit;
   logic [NSRC-1:0] mld_hit;
   logic            load_use;
   logic            br_wait;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign ex_hit[i]  = uses[i] && (|srcs[i]) && ex_wen && (ex_rd == srcs[i]);
      assign mld_hit[i] = uses[i] && (|srcs[i]) && mem_wen && mem_load
                          && (mem_rd == srcs[i]);
   end

   assign load_use = ex_load && (|ex_hit);
   assign br_wait  = id_branch && (ex_hit[0] || mld_hit[0]);
   assign stall    = load_use || br_wait;

   always_comb begin
      if (!(|uses))
         assert_unused_no_stall_R11: assert (!stall);
   end
endmodule

// File: rtl/hzd_branch_ctl.sv
module hzd_branch_ctl
   import hzd_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  fwd_src_e        sel,
   input  logic [XLEN-1:0] rf_val,
   input  logic [XLEN-1:0] mem_val,
   input  logic [XLEN-1:0] wb_val,
   input  logic            id_branch,
   input  logic            br_zero,
   input  logic            stall,
   output logic            take
);
   logic [XLEN-1:0] opnd;
   logic            is_zero;

   always_comb begin
      unique case (sel)
         FS_MEM:  opnd = mem_val;
         FS_WB:   opnd = wb_val;
         default: opnd = rf_val;
      endcase
   end

   assign is_zero = (opnd == '0);
   assign take    = id_branch && !stall && (br_zero ? is_zero : !is_zero);
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
   import hzd_pkg::*;
#(
   parameter int REG_AW       = 5,
   parameter int XLEN         = 32,
   parameter bit WB_TO_ID_FWD = 1'b1
) (
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use_rs1,
   input  logic              id_use_rs2,
   input  logic              id_branch,
   input  logic              id_br_zero,
   input  logic [REG_AW-1:0] ex_rs1,
   input  logic [REG_AW-1:0] ex_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wen,
   input  logic [XLEN-1:0]   rf_rs1_val,
   input  logic [XLEN-1:0]   mem_alu_val,
   input  logic [XLEN-1:0]   wb_val,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic [1:0]        fwd_br,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble,
   output logic              take_target
);
   localparam int NSRC = 2;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hazard_fwd_unit: REG_AW out of range");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("hazard_fwd_unit: XLEN must be positive");
   end

   logic [NSRC-1:0][REG_AW-1:0] ex_srcs;
   logic [NSRC-1:0][REG_AW-1:0] id_srcs;
   logic [NSRC-1:0]             id_uses;
   fwd_src_e [NSRC-1:0]         ex_sel;
   fwd_src_e                    br_sel;
   logic                        stall;
   logic                        mem_alu_ok;
   logic                        br_wb_ok;

   assign ex_srcs    = {ex_rs2, ex_rs1};
   assign id_srcs    = {id_rs2, id_rs1};
   assign id_uses    = {id_use_rs2, id_use_rs1 | id_branch};
   assign mem_alu_ok = mem_wen && !mem_load;

   if (WB_TO_ID_FWD) begin : g_br_wb
      assign br_wb_ok = wb_wen;
   end else begin : g_br_rf
      assign br_wb_ok = 1'b0;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_ex_fwd
      hzd_fwd_pick #(.AW(REG_AW)) u_pick (
         .src    (ex_srcs[i]),
         .mem_rd (mem_rd),
         .mem_ok (mem_wen),
         .wb_rd  (wb_rd),
         .wb_ok  (wb_wen),
         .sel    (ex_sel[i])
      );
   end

   hzd_fwd_pick #(.AW(REG_AW)) u_br_pick (
      .src    (id_rs1),
      .mem_rd (mem_rd),
      .mem_ok (mem_alu_ok),
      .wb_rd  (wb_rd),
      .wb_ok  (br_wb_ok),
      .sel    (br_sel)
   );

   hzd_stall_detect #(.AW(REG_AW), .NSRC(NSRC)) u_stall (
      .srcs      (id_srcs),
      .uses      (id_uses),
      .id_branch (id_branch),
      .ex_rd     (ex_rd),
      .ex_wen    (ex_wen),
      .ex_load   (ex_load),
      .mem_rd    (mem_rd),
      .mem_wen   (mem_wen),
      .mem_load  (mem_load),
      .stall     (stall)
   );

   hzd_branch_ctl #(.XLEN(XLEN)) u_br (
      .sel       (br_sel),
      .rf_val    (rf_rs1_val),
      .mem_val   (mem_alu_val),
      .wb_val    (wb_val),
      .id_branch (id_branch),
      .br_zero   (id_br_zero),
      .stall     (stall),
      .take      (take_target)
   );

   assign fwd_a       = ex_sel[0];
   assign fwd_b       = ex_sel[1];
   assign fwd_br      = br_sel;
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   always_comb begin
      if (take_target)
         assert_slot_kept_R10: assert (!ifid_hold);
      assert_load_branch_wait_R8: assert (stall || !(id_branch && mem_wen && mem_load
                                  && (|id_rs1) && (mem_rd == id_rs1)));
      assert_load_use_wait_R5: assert (stall || !(ex_load && ex_wen && id_use_rs2
                               && (|id_rs2) && (ex_rd == id_rs2)));
      if (br_sel == FS_MEM)
         assert_no_load_bypass_R9: assert (!mem_load);
   end
endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic        id_use_rs1, id_use_rs2, id_branch, id_br_zero;
   logic        ex_wen, ex_load, mem_wen, mem_load, wb_wen;
   logic [31:0] rf_rs1_val, mem_alu_val, wb_val;
   logic [1:0]  fwd_a, fwd_b, fwd_br;
   logic        pc_hold, ifid_hold, idex_bubble, take_target;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   hazard_fwd_unit dut (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
      .id_branch(id_branch), .id_br_zero(id_br_zero), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .mem_rd(mem_rd),
      .mem_wen(mem_wen), .mem_load(mem_load), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .rf_rs1_val(rf_rs1_val), .mem_alu_val(mem_alu_val), .wb_val(wb_val),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_br(fwd_br), .pc_hold(pc_hold),
      .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .take_target(take_target)
   );

   typedef struct packed {
      logic [4:0] rs1, rs2;
      logic       u1, u2, br, bz;
      logic [4:0] xr1, xr2, xrd;
      logic       xw, xl;
      logic [4:0] mrd;
      logic       mw, ml;
      logic [4:0] wrd;
      logic       ww;
      logic [1:0] fa, fb, fbr;
      logic       st, tk;
      logic [3:0] req;
   } vec_t;

   // Values during the table: register file 0, memory-stage result 3, write-back 0.
   localparam int NV = 14;
   localparam vec_t VT [NV] = '{
      '{0,0,0,0,0,0, 3,4, 0,0,0, 3,1,0, 4,1, 1,2,0,0,0, 1},  // R1 and R2
      '{0,0,0,0,0,0, 5,5, 0,0,0, 5,1,0, 5,1, 1,1,0,0,0, 3},  // R3 priority
      '{0,0,1,0,0,0, 0,0, 0,1,1, 0,1,0, 0,1, 0,0,0,0,0, 4},  // R4 register 0
      '{2,6,1,1,0,0, 1,1, 6,1,1, 0,0,0, 0,0, 0,0,0,1,0, 5},  // R5 load-use
      '{2,6,1,0,0,0, 1,1, 6,1,1, 0,0,0, 0,0, 0,0,0,0,0, 11}, // R11 unused source
      '{6,0,1,0,0,0, 1,1, 6,1,0, 0,0,0, 0,0, 0,0,0,0,0, 6},  // R6 ALU writer
      '{8,0,0,0,1,1, 1,1, 8,1,0, 0,0,0, 0,0, 0,0,0,1,0, 7},  // R7 branch vs execute
      '{9,0,0,0,1,1, 1,1, 0,0,0, 9,1,1, 0,0, 0,0,0,1,0, 8},  // R8 branch vs load in memory
      '{9,0,0,0,1,0, 1,1, 0,0,0, 9,1,0, 0,0, 0,0,1,0,1, 9},  // R9 memory bypass, nonzero
      '{10,0,0,0,1,1, 1,1, 0,0,0, 0,0,0, 10,1, 0,0,2,0,1, 9}, // R9 write-back bypass, zero
      '{11,0,0,0,1,0, 1,1, 0,0,0, 0,0,0, 0,0, 0,0,0,0,0, 10}, // R10 nonzero test, not taken
      '{11,0,0,0,1,1, 1,1, 0,0,0, 0,0,0, 0,0, 0,0,0,0,1, 10}, // R10 zero test, taken
      '{0,0,0,0,1,1, 1,1, 0,1,0, 0,0,0, 0,0, 0,0,0,0,1, 4},  // R4 branch on register 0
      '{0,0,0,0,0,0, 7,7, 0,0,0, 7,0,0, 7,1, 2,2,0,0,0, 2}   // R2 memory write disabled
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      id_rs1 = v.rs1; id_rs2 = v.rs2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
      id_branch = v.br; id_br_zero = v.bz; ex_rs1 = v.xr1; ex_rs2 = v.xr2;
      ex_rd = v.xrd; ex_wen = v.xw; ex_load = v.xl; mem_rd = v.mrd;
      mem_wen = v.mw; mem_load = v.ml; wb_rd = v.wrd; wb_wen = v.ww;
   endtask

   // Behavioural pipeline model for stall counting.
   typedef struct packed {
      logic [4:0] rd, rs1, rs2;
      logic       u1, u2, wen, ld, br;
   } ins_t;

   function automatic ins_t nop();
      return '0;
   endfunction

   task automatic run_prog(input ins_t p0, input ins_t p1, input ins_t p2,
                           input string tag, input int exp_stalls);
      ins_t prog [3];
      ins_t s_id, s_ex, s_mem, s_wb;
      int   pc = 0;
      int   stalls = 0;
      prog[0] = p0; prog[1] = p1; prog[2] = p2;
      s_id = nop(); s_ex = nop(); s_mem = nop(); s_wb = nop();
      rf_rs1_val = 32'd0; mem_alu_val = 32'd0; wb_val = 32'd0;
      for (int cyc = 0; cyc < 12; cyc++) begin
         @(negedge clk);
         id_rs1 = s_id.rs1; id_rs2 = s_id.rs2; id_use_rs1 = s_id.u1; id_use_rs2 = s_id.u2;
         id_branch = s_id.br; id_br_zero = 1'b0;
         ex_rs1 = s_ex.rs1; ex_rs2 = s_ex.rs2; ex_rd = s_ex.rd; ex_wen = s_ex.wen;
         ex_load = s_ex.ld; mem_rd = s_mem.rd; mem_wen = s_mem.wen; mem_load = s_mem.ld;
         wb_rd = s_wb.rd; wb_wen = s_wb.wen;
         #1;
         s_wb  = s_mem;
         s_mem = s_ex;
         if (pc_hold) begin
            stalls++;
            s_ex = nop();
         end else begin
            s_ex = s_id;
            s_id = (pc < 3) ? prog[pc] : nop();
            pc++;
         end
      end
      chk(tag, stalls, exp_stalls);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      ins_t ld1, add_r1, br_r1, use_r1, spacer;
      drive('0);
      rf_rs1_val = 32'd0; mem_alu_val = 32'd3; wb_val = 32'd0;
      @(negedge clk); #1;
      // Quiet inputs: everything at its idle value.
      chk("R4 idle fwd_a", int'(fwd_a), 0);
      chk("R5 idle hold", int'({pc_hold, ifid_hold, idex_bubble}), 0);
      chk("R10 idle take", int'(take_target), 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VT[i]);
         #1;
         chk($sformatf("R%0d row%0d fwd_a", VT[i].req, i), int'(fwd_a), int'(VT[i].fa));
         chk($sformatf("R%0d row%0d fwd_b", VT[i].req, i), int'(fwd_b), int'(VT[i].fb));
         chk($sformatf("R%0d row%0d fwd_br", VT[i].req, i), int'(fwd_br), int'(VT[i].fbr));
         chk($sformatf("R%0d row%0d pc_hold", VT[i].req, i), int'(pc_hold), int'(VT[i].st));
         chk($sformatf("R%0d row%0d ifid_hold", VT[i].req, i), int'(ifid_hold), int'(VT[i].st));
         chk($sformatf("R%0d row%0d idex_bubble", VT[i].req, i), int'(idex_bubble), int'(VT[i].st));
         chk($sformatf("R%0d row%0d take", VT[i].req, i), int'(take_target), int'(VT[i].tk));
      end

      // R9: tested value follows the bypass source (memory value now zero).
      @(negedge clk);
      drive(VT[8]);
      id_br_zero = 1'b1; mem_alu_val = 32'd0;
      #1;
      chk("R9 zero via memory bypass", int'(take_target), 1);

      // R10: stalled branch never redirects even when the condition holds.
      @(negedge clk);
      drive(VT[6]);
      rf_rs1_val = 32'd0;
      #1;
      chk("R10 stalled branch take", int'(take_target), 0);

      ld1    = '{rd:5'd1, rs1:5'd2, rs2:5'd0, u1:1'b1, u2:1'b0, wen:1'b1, ld:1'b1, br:1'b0};
      add_r1 = '{rd:5'd1, rs1:5'd2, rs2:5'd3, u1:1'b1, u2:1'b1, wen:1'b1, ld:1'b0, br:1'b0};
      br_r1  = '{rd:5'd0, rs1:5'd1, rs2:5'd0, u1:1'b1, u2:1'b0, wen:1'b0, ld:1'b0, br:1'b1};
      use_r1 = '{rd:5'd4, rs1:5'd5, rs2:5'd1, u1:1'b1, u2:1'b1, wen:1'b1, ld:1'b0, br:1'b0};
      spacer = '{rd:5'd7, rs1:5'd6, rs2:5'd6, u1:1'b1, u2:1'b1, wen:1'b1, ld:1'b0, br:1'b0};

      run_prog(ld1, br_r1, nop(), "R8 load then branch stalls", 2);
      run_prog(ld1, use_r1, nop(), "R5 load then use stalls", 1);
      run_prog(ld1, spacer, use_r1, "R6 load, spacer, use stalls", 0);
      run_prog(add_r1, br_r1, nop(), "R7 ALU then branch stalls", 1);
      run_prog(add_r1, use_r1, nop(), "R6 ALU then use stalls", 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule